// File: doc/BRIEF.md
# Backlight PWM Generator with Prescaler

This block drives a display backlight with a pulse-width modulated signal that software sets up through a small register port. The block runs from a fixed 6 MHz clock. A 7-bit prescaler divides that clock by a value from 1 to 128 to make count ticks. An 8-bit period counter advances once per tick, so one PWM period is 256 ticks. The output is high while the period counter is below the programmed level. The result is gated by two enables: an output-enable flag that sits in the divider register, and a separate backlight-enable register.

The divider is stored as the division ratio minus one. The longest period is therefore 128 × 256 clocks, about 5.46 ms (roughly 183 Hz). To change the ratio while running, software first writes zero to the divider register, which stops and clears the generator. It then writes the new ratio with the enable flag set. Duty updates are held back until the next period boundary, so a period is never cut short by a level change. Only non-inverted polarity exists.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, all three registers read 0 and `pwm_o` is low.
- R2: Register map. Address 0 holds the divider field in bits 6:0 and the output-enable flag in bit 7. Address 1 holds the 8-bit level. Address 2 holds the backlight enable in bit 0, and its bits 7:1 read as 0. A write takes effect at the clock edge where `wr_en_i` is high. `rdata_o` combinationally shows the register that `addr_i` selects.
- R3: With divider field D, the period counter advances once every D+1 input clocks, so a PWM period lasts 256×(D+1) clocks.
- R4: For a level L below 0xFF, `pwm_o` is high for L×(D+1) consecutive clocks of each period and low for the rest.
- R5: Level 0 keeps `pwm_o` low for the whole period, and level 0xFF keeps it high for the whole period.
- R6: A level write while running does not change the current period. It takes effect from the next period boundary.
- R7: When the output-enable flag is 0, `pwm_o` is low and both counters are held at zero. Setting the flag starts a fresh period at count 0, so `pwm_o` is high for the first L×(D+1) clocks.
- R8: When the backlight enable is 0, `pwm_o` is low. The PWM core keeps running, and the output resumes when the enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 6 MHz base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the register at `addr_i` |
| pwm_o | output | 1 | Gated backlight PWM output |

## Verification
The bench measures high-run lengths and high counts over whole periods at several divider values, up to the largest field of 127. A prescaler that is off by one, or that ignores the stored minus-one, would stretch or shrink these runs by a whole tick multiple. It targets the two extreme levels: a plain less-than compare would leave a one-tick gap at 0xFF.

Two timing cases are checked directly. For the first, the bench writes a new level just after the falling edge of a period and confirms the rest of that period stays low. A design that loads the level at once would raise the output mid-period. For the second, after a disable and re-enable, the first high run must be exactly the full level. A design that keeps a stale count would start mid-period.

Gating by the backlight enable is checked for a silent output and for correct resumption. Readback checks catch a flag packed into the wrong bit.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned ADDR_W = 2;
  parameter int unsigned DIV_W  = 7;
  parameter int unsigned CNT_W  = 8;

  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_BL   = 2'd2;

  typedef struct packed {
    logic             out_en;
    logic [DIV_W-1:0] div_m1;
  } div_reg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output div_reg_t          div_reg_o,
  output logic [CNT_W-1:0]  duty_o,
  output logic              bl_en_o
);
  div_reg_t           div_q;
  logic [CNT_W-1:0]   duty_q;
  logic               bl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      duty_q <= '0;
      bl_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_DIV:  div_q  <= div_reg_t'(wdata_i[DIV_W:0]);
        ADDR_DUTY: duty_q <= wdata_i[CNT_W-1:0];
        ADDR_BL:   bl_q   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_DIV:  rdata_o = DATA_W'(div_q);
      ADDR_DUTY: rdata_o = DATA_W'(duty_q);
      ADDR_BL:   rdata_o = DATA_W'(bl_q);
      default:   rdata_o = '0;
    endcase
  end

  assign div_reg_o = div_q;
  assign duty_o    = duty_q;
  assign bl_en_o   = bl_q;

  // R2
  wr_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_DIV) |=> (div_reg_o == div_reg_t'($past(wdata_i[DIV_W:0]))));
  // R2
  bl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_BL) |=> $stable(bl_en_o));
endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler
  import bl_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;

  // >= tolerates a field shrink while running
  assign tick_o = en_i && (pre_q >= div_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!en_i)   pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  // R3
  pre_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_o) |=> (pre_q == $past(pre_q) + 1'b1));
  // R7
  pre_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_raw_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lvl_q;
  logic             wrap;

  assign wrap = tick_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      lvl_q <= duty_i;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (wrap)   lvl_q <= duty_i;
    end
  end

  // full scale is solid high
  assign pwm_raw_o = en_i && ((lvl_q == CNT_MAX) || (cnt_q < lvl_q));

  // R6
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap) |=> $stable(lvl_q));
  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R5
  full_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lvl_q == CNT_MAX) |-> pwm_raw_o);
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o
);
  div_reg_t         div_reg;
  logic [CNT_W-1:0] duty;
  logic             bl_en;
  logic             tick;
  logic             pwm_raw;

  bl_pwm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .div_reg_o (div_reg),
    .duty_o    (duty),
    .bl_en_o   (bl_en)
  );

  bl_pwm_prescaler u_pre (
    .clk_i, .rst_ni,
    .en_i     (div_reg.out_en),
    .div_m1_i (div_reg.div_m1),
    .tick_o   (tick)
  );

  bl_pwm_core u_core (
    .clk_i, .rst_ni,
    .en_i      (div_reg.out_en),
    .tick_i    (tick),
    .duty_i    (duty),
    .pwm_raw_o (pwm_raw)
  );

  assign pwm_o = pwm_raw && bl_en;

  // R8
  bl_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bl_en |-> !pwm_o);
  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_reg.out_en |-> !pwm_o);
endmodule

// File: tb/bl_pwm_top_bench.sv
`timescale 1ns/1ps
module bl_pwm_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwm;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bl_pwm_top u_bl_pwm_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    addr = a; #1;
    check(rdata == exp, req, rdata, exp);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm) h++;
      @(negedge clk);
    end
  endtask

  task automatic run_len(output int h);
    while (pwm) @(negedge clk);
    while (!pwm) @(negedge clk);
    h = 0;
    while (pwm) begin h++; @(negedge clk); end
  endtask

  task automatic t_reset();
    rd_chk(2'd0, 0, "R1");
    rd_chk(2'd1, 0, "R1");
    rd_chk(2'd2, 0, "R1");
    check(pwm == 1'b0, "R1", pwm, 0);
  endtask

  task automatic t_regmap();
    wr(2'd0, 8'h05); rd_chk(2'd0, 8'h05, "R2");
    wr(2'd1, 8'h40); rd_chk(2'd1, 8'h40, "R2");
    wr(2'd2, 8'hFF); rd_chk(2'd2, 8'h01, "R2");
    check(pwm == 1'b0, "R7", pwm, 0);
    wr(2'd0, 8'h00); rd_chk(2'd0, 0, "R2");
  endtask

  task automatic t_basic();
    int h;
    wr(2'd0, 8'h80);
    rd_chk(2'd0, 8'h80, "R2");
    count_high(256, h); check(h == 64, "R4", h, 64);
    run_len(h);         check(h == 64, "R4", h, 64);
  endtask

  task automatic t_div(input logic [6:0] f, input logic [7:0] lvl);
    int h;
    wr(2'd0, 8'h00);
    wr(2'd1, lvl);
    wr(2'd0, {1'b1, f});
    rd_chk(2'd0, {1'b1, f}, "R2");
    run_len(h);
    check(h == int'(lvl) * (int'(f) + 1), "R3", h, int'(lvl) * (int'(f) + 1));
  endtask

  task automatic t_extremes();
    int h;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h80);
    count_high(256, h); check(h == 0, "R5", h, 0);
    wr(2'd1, 8'hFF);
    count_high(300, h);
    count_high(256, h); check(h == 256, "R5", h, 256);
  endtask

  task automatic t_boundary();
    int h;
    wr(2'd0, 8'h00); wr(2'd1, 8'd64); wr(2'd0, 8'h80);
    while (!pwm) @(negedge clk);
    while (pwm) @(negedge clk);
    wr(2'd1, 8'd200);
    count_high(150, h); check(h == 0, "R6", h, 0);
    count_high(100, h);
    count_high(256, h); check(h == 200, "R6", h, 200);
  endtask

  task automatic t_restart();
    int h;
    wr(2'd1, 8'd64);
    count_high(300, h);
    wr(2'd0, 8'h00);
    check(pwm == 1'b0, "R7", pwm, 0);
    count_high(100, h); check(h == 0, "R7", h, 0);
    wr(2'd0, 8'h80);
    count_high(64, h); check(h == 64, "R7", h, 64);
    check(pwm == 1'b0, "R7", pwm, 0);
  endtask

  task automatic t_backlight();
    int h;
    wr(2'd2, 8'h00);
    rd_chk(2'd2, 0, "R8");
    count_high(256, h); check(h == 0, "R8", h, 0);
    wr(2'd2, 8'h01);
    count_high(256, h); check(h == 64, "R8", h, 64);
  endtask

  initial begin
    #55 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_basic();
    t_div(7'd2, 8'd64);
    t_div(7'd127, 8'd128);
    t_extremes();
    t_boundary();
    t_restart();
    t_backlight();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule